// File: doc/BRIEF.md
# Conversion Mode and Data-Ready Controller

This block owns the configuration byte of a delta-sigma converter. It decides when conversions are started and keeps the result register and the ready flag that a host reads back. A serial front end delivers configuration-byte writes, plus one strobe when a result read begins and another when it ends. A modelled converter core delivers a completion pulse together with its result word. The block sends the core a start request, a continuous/one-shot level, and the stored rate and gain fields.

The ready flag is not a plain sticky done flag. A low flag tells the reader that the result just shifted out is fresh. In one-shot mode the flag stays low after the data has been read, until a new start is written. In continuous mode, reading fresh data raises the flag, and the next completion clears it again. A completion that arrives while a read is in progress is held back until the read ends, so the bytes being shifted out never change mid-read.

Top module: `adc_mode_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x90 and `res_data` is zero. The readback layout is bit 7 ready flag, bits 6:5 spare, bit 4 continuous mode, bits 3:2 rate and bits 1:0 gain. After reset the block is in continuous mode with the ready flag high.
- R2: A write with bit 4 set selects continuous mode. It sets the ready flag to 1 whatever value is written to bit 7, and `conv_start` is high for exactly the following cycle.
- R3: A write with bit 4 clear and bit 7 set starts one one-shot conversion. `conv_start` pulses on the next cycle, and the ready flag reads 1 until that conversion completes.
- R4: A write with bits 7 and 4 both clear starts nothing and leaves the ready flag unchanged. The other fields take the written values, so rewriting the current settings changes nothing.
- R5: A completion in continuous mode, or during a one-shot conversion, loads `conv_data` into `res_data` and clears the ready flag, both visible one cycle later.
- R6: A completion in one-shot mode with no conversion in progress is ignored.
- R7: In one-shot mode, once the flag is low it stays low through reads until a write starts a new conversion.
- R8: In continuous mode, the end of a read that began with the flag low sets the flag to 1. The flag stays 1 until the next completion.
- R9: A completion seen between `rd_start` (inclusive) and `rd_end` (exclusive) leaves `res_data` unchanged. It is applied in the cycle after `rd_end`, which also clears the ready flag.
- R10: A completion in the same cycle as a configuration write is dropped.
- R11: `conv_rate`, `conv_gain` and `conv_cont` always equal the stored fields shown in `cfg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte written |
| rd_start | input | 1 | Result read begins |
| rd_end | input | 1 | Result read ends |
| conv_done | input | 1 | Conversion complete pulse from the core |
| conv_data | input | RES_W | Result word from the core |
| conv_start | output | 1 | One-cycle conversion start request |
| conv_cont | output | 1 | Continuous mode level to the core |
| conv_rate | output | 2 | Stored rate/resolution field |
| conv_gain | output | 2 | Stored gain field |
| res_data | output | RES_W | Latched result |
| cfg_rdata | output | 8 | Configuration readback including ready flag |

## Verification
The properties assume that `conv_done` is a single-cycle pulse and that `rd_end` arrives only after a matching `rd_start`, never in the same cycle as it. They also assume that a write that changes nothing is presented with the currently read-back fields. The stimulus drives every strobe for one cycle only and brackets each read with a separate start and end. It places completions both inside and outside reads, and one completion on the same cycle as a write, so the deferral and the dropping of completions are both exercised.

// File: rtl/adc_mode_ctrl.sv
module adc_mode_ctrl #(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             rd_start,
  input  logic             rd_end,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             conv_start,
  output logic             conv_cont,
  output logic [1:0]       conv_rate,
  output logic [1:0]       conv_gain,
  output logic [RES_W-1:0] res_data,
  output logic [7:0]       cfg_rdata
);

  logic             rdy, cont, busy, reading, pend;
  logic [1:0]       spare, rate, gain;
  logic [RES_W-1:0] pend_data;

  wire wr_start = cfg_we & (cfg_wdata[4] | cfg_wdata[7]);
  wire take     = conv_done & ~cfg_we & (cont | busy);
  wire read_end = rd_end & reading;
  wire hold     = (reading | rd_start) & ~read_end;

  assign conv_cont = cont;
  assign conv_rate = rate;
  assign conv_gain = gain;
  assign cfg_rdata = {rdy, spare, cont, rate, gain};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy        <= 1'b1;
      cont       <= 1'b1;
      busy       <= 1'b0;
      reading    <= 1'b0;
      pend       <= 1'b0;
      spare      <= '0;
      rate       <= '0;
      gain       <= '0;
      pend_data  <= '0;
      res_data   <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= wr_start;

      if (rd_start)      reading <= 1'b1;
      else if (read_end) reading <= 1'b0;

      if (read_end && cont && !rdy) rdy <= 1'b1;

      if (read_end && pend) begin
        res_data <= pend_data;
        rdy      <= 1'b0;
        pend     <= 1'b0;
      end

      if (take) begin
        busy <= 1'b0;
        if (hold) begin
          pend      <= 1'b1;
          pend_data <= conv_data;
        end else begin
          res_data <= conv_data;
          rdy      <= 1'b0;
          pend     <= 1'b0;
        end
      end

      if (cfg_we) begin
        cont  <= cfg_wdata[4];
        spare <= cfg_wdata[6:5];
        rate  <= cfg_wdata[3:2];
        gain  <= cfg_wdata[1:0];
        if (wr_start) begin
          rdy  <= 1'b1;
          busy <= ~cfg_wdata[4];
          pend <= 1'b0;
        end
      end
    end
  end

endmodule

module adc_mode_ctrl_chk #(
  parameter int RES_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [7:0]       cfg_wdata,
  input logic             rd_end,
  input logic             conv_done,
  input logic             conv_start,
  input logic             conv_cont,
  input logic [RES_W-1:0] res_data,
  input logic [7:0]       cfg_rdata
);

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_wdata[4] || cfg_wdata[7]) |=> conv_start);

  p_no_stray_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> !conv_start);

  p_cont_rdy_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[4] |=> cfg_rdata[7] && conv_cont);

  p_result_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done && !rd_end |=> $stable(res_data));

  p_oneshot_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we && !cfg_rdata[4] && !cfg_rdata[7] |=> !cfg_rdata[7]);

  p_null_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wdata[7] && !cfg_rdata[4] && cfg_wdata[6:0] == cfg_rdata[6:0]
      && !rd_end |=> $stable(cfg_rdata));

endmodule

bind adc_mode_ctrl adc_mode_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .rd_end(rd_end), .conv_done(conv_done), .conv_start(conv_start),
  .conv_cont(conv_cont), .res_data(res_data), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_adc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_adc_mode_ctrl;
  localparam int RES_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic rd_start = 1'b0, rd_end = 1'b0, conv_done = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic conv_start, conv_cont;
  logic [1:0] conv_rate, conv_gain;
  logic [RES_W-1:0] res_data;
  logic [7:0] cfg_rdata;

  int checks = 0, fails = 0;
  bit done_drv = 1'b0;
  logic [RES_W+8:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  adc_mode_ctrl #(.RES_W(RES_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_start(rd_start), .rd_end(rd_end), .conv_done(conv_done),
    .conv_data(conv_data), .conv_start(conv_start), .conv_cont(conv_cont),
    .conv_rate(conv_rate), .conv_gain(conv_gain), .res_data(res_data),
    .cfg_rdata(cfg_rdata)
  );

  task automatic step(input logic we, input logic [7:0] wd, input logic rs,
                      input logic re, input logic dn, input logic [RES_W-1:0] dd,
                      input logic [7:0] e_rd, input logic [RES_W-1:0] e_res,
                      input logic e_st, input string tag);
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; rd_start = rs; rd_end = re;
    conv_done = dn; conv_data = dd;
    @(posedge clk);
    exp_q.push_back({e_st, e_rd, e_res});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        logic [RES_W+8:0] e;
        logic [RES_W+8:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {conv_start, cfg_rdata, res_data};
        checks++;
        if (a !== e || conv_rate !== e[RES_W+3:RES_W+2] ||
            conv_gain !== e[RES_W+1:RES_W] || conv_cont !== e[RES_W+4]) begin
          fails++;
          $display("FAIL %s: start/rdata/res actual %0h/%02h/%05h expected %0h/%02h/%05h",
                   t, a[RES_W+8], a[RES_W+7:RES_W], a[RES_W-1:0],
                   e[RES_W+8], e[RES_W+7:RES_W], e[RES_W-1:0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done_drv) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 8'h00, 0, 0, 0, 18'h0,     8'h90, 18'h0,     0, "R1 reset");
    step(0, 8'h00, 0, 0, 1, 18'h12345, 8'h10, 18'h12345, 0, "R5 cont load");
    step(0, 8'h00, 1, 0, 0, 18'h0,     8'h10, 18'h12345, 0, "R8 read start");
    step(0, 8'h00, 0, 0, 0, 18'h0,     8'h10, 18'h12345, 0, "R8 reading");
    step(0, 8'h00, 0, 1, 0, 18'h0,     8'h90, 18'h12345, 0, "R8 read end sets rdy");
    step(0, 8'h00, 0, 0, 0, 18'h0,     8'h90, 18'h12345, 0, "R8 rdy holds");
    step(1, 8'h0B, 0, 0, 0, 18'h0,     8'h8B, 18'h12345, 0, "R4 R11 field write");
    step(0, 8'h00, 0, 0, 1, 18'h00111, 8'h8B, 18'h12345, 0, "R6 idle done ignored");
    step(1, 8'h8B, 0, 0, 0, 18'h0,     8'h8B, 18'h12345, 1, "R3 one-shot start");
    step(0, 8'h00, 0, 0, 0, 18'h0,     8'h8B, 18'h12345, 0, "R3 pulse ends");
    step(0, 8'h00, 0, 0, 1, 18'h00ABC, 8'h0B, 18'h00ABC, 0, "R5 one-shot load");
    step(0, 8'h00, 1, 0, 0, 18'h0,     8'h0B, 18'h00ABC, 0, "R7 read start");
    step(0, 8'h00, 0, 1, 0, 18'h0,     8'h0B, 18'h00ABC, 0, "R7 rdy stays low");
    step(0, 8'h00, 0, 0, 1, 18'h3FFFF, 8'h0B, 18'h00ABC, 0, "R6 done after one-shot");
    step(1, 8'h0B, 0, 0, 0, 18'h0,     8'h0B, 18'h00ABC, 0, "R4 null write");
    step(1, 8'h1B, 0, 0, 0, 18'h0,     8'h9B, 18'h00ABC, 1, "R2 cont start rdy0 written");
    step(0, 8'h00, 1, 0, 0, 18'h0,     8'h9B, 18'h00ABC, 0, "R9 read start");
    step(0, 8'h00, 0, 0, 1, 18'h22222, 8'h9B, 18'h00ABC, 0, "R9 deferred");
    step(0, 8'h00, 0, 0, 0, 18'h0,     8'h9B, 18'h00ABC, 0, "R9 still deferred");
    step(0, 8'h00, 0, 1, 0, 18'h0,     8'h1B, 18'h22222, 0, "R9 applied after end");
    step(1, 8'hF4, 0, 0, 1, 18'h11111, 8'hF4, 18'h22222, 1, "R10 done with write dropped");
    step(0, 8'h00, 0, 0, 1, 18'h01111, 8'h74, 18'h01111, 0, "R5 R11 load after rewrite");
    @(negedge clk);
    cfg_we = 0; conv_done = 0; rd_start = 0; rd_end = 0;
    @(posedge clk); #2;
    done_drv = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule